// File: doc/BRIEF.md
# Presettable Synchronous Binary Counter Stage

This block is one stage of a synchronous binary up counter, 4 bits wide by default. On each rising clock edge it can clear itself, take a preset value, add one, or keep its value. A clear request beats a load request, and a load request beats counting. Counting needs two enables at once: a wide count enable and a chain enable.

The stage drives a terminal-count flag. The flag is high when the count is all ones and the chain enable is high. It follows the chain enable through combinational logic and ignores the wide enable. To build a wider counter, connect the flag of one stage to the chain enable of the next. Every stage shares the clock, clear, load and wide enable. The chain then counts as one binary counter without a ripple delay between registers.

The register has no reset value. Software or the surrounding logic must apply one synchronous clear before the count is used.

Top module: `sync_preset_counter`

## Requirements
- R1: The count changes only at a rising clock edge; input changes between edges leave `count` unchanged.
- R2: When `clr_n` is 0 at an edge, `count` becomes 0, whatever `load_n`, `preset` and both enables are.
- R3: When `clr_n` is 1 and `load_n` is 0 at an edge, `count` takes `preset`, whatever both enables are.
- R4: When `clr_n` and `load_n` are 1 and both `en_wide` and `en_chain` are 1 at an edge, `count` increases by one.
- R5: When `clr_n` and `load_n` are 1 and either enable is 0 at an edge, `count` keeps its value.
- R6: An increment from all ones (4'hF at the default width) gives 0.
- R7: `term` is 1 exactly when `en_chain` is 1 and `count` is all ones; `en_wide` has no effect on it.
- R8: `term` follows `en_chain` within the same clock cycle, with no edge needed. After a load or clear it reflects the new count.
- R9: When two stages share the clock, clear, load and `en_wide`, with the low stage's `term` driving the high stage's `en_chain`, the pair counts as one 8-bit binary counter and wraps from 8'hFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous preset load, active low |
| preset | input | WIDTH | Value loaded when `load_n` is 0 |
| en_wide | input | 1 | Count enable shared by all stages of a chain |
| en_chain | input | 1 | Count enable that also gates `term`; fed by the previous stage |
| count | output | WIDTH | Current count |
| term | output | 1 | Terminal count: `en_chain` and count all ones |

## Verification
The hardest case to reach from the ports is the upper stage of a cascade reaching its own terminal count. That happens only after the whole chain has counted through 255 edges. It is also the only point where the 8'hFF to 0 carry crosses a stage boundary.

The bench clears the two-stage chain and holds both enables high for more than one full 256-count period. It compares the combined value against a reference count at every edge, so it sees the upper stage's `term` rise at 8'hFF. A separate directed test loads all ones, then toggles `en_chain` and `en_wide` between edges. This shows that `term` follows `en_chain` at once, while `count` does not move until an edge.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  // Action taken by a counter stage at the next rising edge, in priority order.
  typedef enum logic [1:0] {
    ACT_CLEAR = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_INCR  = 2'd2,
    ACT_HOLD  = 2'd3
  } cnt_act_e;
endpackage

// File: rtl/cnt_act_dec.sv
module cnt_act_dec
  import cnt_pkg::*;
(
  input  logic     clr_n,
  input  logic     load_n,
  input  logic     en_wide,
  input  logic     en_chain,
  output cnt_act_e act
);
  // Fixed priority: clear, then load, then count, otherwise hold.
  always_comb begin
    if (!clr_n)                   act = ACT_CLEAR;
    else if (!load_n)             act = ACT_LOAD;
    else if (en_wide && en_chain) act = ACT_INCR;
    else                          act = ACT_HOLD;
  end
endmodule

// File: rtl/cnt_state_reg.sv
module cnt_state_reg
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  cnt_act_e         act,
  input  logic [WIDTH-1:0] preset,
  output logic [WIDTH-1:0] count
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;
  logic             upd_en;

  // Next-state selection.
  always_comb begin
    unique case (act)
      ACT_CLEAR: count_d = '0;
      ACT_LOAD:  count_d = preset;
      ACT_INCR:  count_d = count_q + ONE;
      default:   count_d = count_q;
    endcase
  end

  assign upd_en = (act != ACT_HOLD);

  // State register: no reset value, a synchronous clear initialises it.
  always_ff @(posedge clk) begin
    if (upd_en) count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/cnt_term_det.sv
module cnt_term_det #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] count,
  input  logic             en_chain,
  output logic             term
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  // Look-ahead carry: decoded from the register plus the chain enable only.
  assign term = en_chain && (count == ALL_ONES);
endmodule

// File: rtl/sync_preset_counter.sv
module sync_preset_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic [WIDTH-1:0] preset,
  input  logic             en_wide,
  input  logic             en_chain,
  output logic [WIDTH-1:0] count,
  output logic             term
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  cnt_act_e act;

  cnt_act_dec u_dec (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .en_wide  (en_wide),
    .en_chain (en_chain),
    .act      (act)
  );

  cnt_state_reg #(.WIDTH(WIDTH)) u_reg (
    .clk    (clk),
    .act    (act),
    .preset (preset),
    .count  (count)
  );

  cnt_term_det #(.WIDTH(WIDTH)) u_term (
    .count    (count),
    .en_chain (en_chain),
    .term     (term)
  );

  // A cycle that follows a clear cycle must show zero.
  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (!clr_n)
    $rose(clr_n) |-> (count == '0));

  assert_load_preset_R3: assert property (@(posedge clk) disable iff (!clr_n)
    (!load_n) |=> (count == $past(preset)));

  // Covers the 1111 -> 0000 wrap as well (R6).
  assert_incr_step_R4: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_wide && en_chain) |=> (count == $past(count) + ONE));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_wide && en_chain)) |=> $stable(count));

  assert_term_gated_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (!en_chain) |-> (!term));
endmodule

// File: tb/sync_preset_counter_tb.sv
module sync_preset_counter_tb;
  logic       clk;
  logic       clr_n, load_n, en_wide, en_chain;
  logic [3:0] preset, preset_hi;
  logic [3:0] count_lo, count_hi;
  logic       term_lo, term_hi;

  int checks   = 0;
  int failures = 0;

  // Low stage is the device under test; a second stage forms a cascade (R9).
  sync_preset_counter #(.WIDTH(4)) u_dut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset),
    .en_wide(en_wide), .en_chain(en_chain), .count(count_lo), .term(term_lo)
  );

  sync_preset_counter #(.WIDTH(4)) u_hi (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .preset(preset_hi),
    .en_wide(en_wide), .en_chain(term_lo), .count(count_hi), .term(term_hi)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // Vector fields: clr_n, load_n, en_wide, en_chain, preset[3:0], exp_count[3:0], exp_term
  localparam int NVEC = 12;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 1'b1, 1'b1, 4'h5, 4'h0, 1'b0},  // R2 clear
    {1'b1, 1'b0, 1'b0, 1'b0, 4'hE, 4'hE, 1'b0},  // R3 load, enables low
    {1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'hF, 1'b1},  // R4 increment, R7 term
    {1'b1, 1'b1, 1'b0, 1'b1, 4'h0, 4'hF, 1'b1},  // R5 hold, R7 en_wide no effect
    {1'b1, 1'b1, 1'b1, 1'b0, 4'h0, 4'hF, 1'b0},  // R5 hold, R7 gated off
    {1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0},  // R6 wrap
    {1'b0, 1'b0, 1'b1, 1'b1, 4'h9, 4'h0, 1'b0},  // R2 clear beats load
    {1'b1, 1'b0, 1'b0, 1'b0, 4'hF, 4'hF, 1'b0},  // R3 load all ones
    {1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h0, 1'b0},  // R6 wrap after load
    {1'b1, 1'b1, 1'b1, 1'b1, 4'h0, 4'h1, 1'b0},  // R4 increment
    {1'b1, 1'b0, 1'b1, 1'b1, 4'hA, 4'hA, 1'b0},  // R3 load beats count
    {1'b1, 1'b1, 1'b0, 1'b0, 4'h3, 4'hA, 1'b0}   // R5 both low hold
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic w, input logic e,
                       input logic [3:0] p);
    @(negedge clk);
    clr_n = c; load_n = l; en_wide = w; en_chain = e; preset = p;
  endtask

  // Watchdog: an expired run counts as a failure and still prints the summary.
  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clr_n = 1'b0; load_n = 1'b1; en_wide = 1'b0; en_chain = 1'b0;
    preset = 4'h0; preset_hi = 4'h3;

    // Reset state: the first edge clears (R2).
    @(posedge clk); #1;
    check("R2 reset", {4'h0, count_lo}, 8'h00);
    check("R2 reset hi", {4'h0, count_hi}, 8'h00);

    // Vector table.
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      @(posedge clk); #1;
      check($sformatf("vec%0d count", i), {4'h0, count_lo}, {4'h0, VEC[i][4:1]});
      check($sformatf("vec%0d term R7", i), {7'h0, term_lo}, {7'h0, VEC[i][0]});
    end

    // R8 / R1: term follows en_chain mid-cycle; count does not move between edges.
    drive(1'b1, 1'b0, 1'b0, 1'b0, 4'hF);
    @(posedge clk); #1;
    check("R8 term off after load", {7'h0, term_lo}, 8'h00);
    en_chain = 1'b1; #1;
    check("R8 term follows en_chain", {7'h0, term_lo}, 8'h01);
    load_n = 1'b1; en_wide = 1'b1; preset = 4'h2; #1;
    check("R1 no change between edges", {4'h0, count_lo}, 8'h0F);
    en_wide = 1'b0; #1;
    check("R7 en_wide ignored by term", {7'h0, term_lo}, 8'h01);
    en_chain = 1'b0; #1;
    check("R8 term drops with en_chain", {7'h0, term_lo}, 8'h00);

    // R9: cascade counts as one 8-bit counter through a full wrap.
    drive(1'b0, 1'b1, 1'b1, 1'b1, 4'h0);
    @(posedge clk); #1;
    check("R9 cascade cleared", {count_hi, count_lo}, 8'h00);
    clr_n = 1'b1;
    for (int k = 1; k <= 300; k++) begin
      @(posedge clk); #1;
      check("R9 cascade count", {count_hi, count_lo}, 8'(k));
      if (k == 255) check("R9 high stage term at FF", {7'h0, term_hi}, 8'h01);
      if (k == 256) check("R9 cascade wrap", {7'h0, term_hi}, 8'h00);
    end

    // R5 via cascade: en_wide low freezes both stages.
    drive(1'b1, 1'b1, 1'b0, 1'b1, 4'h0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R5 cascade frozen", {count_hi, count_lo}, 8'(300));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule